// File: doc/BRIEF.md
# Self-Test Session Sequencer

This block runs one built-in self-test session at a time for a circuit under test. On a start request it moves the circuit under test into test mode and hands a seed to the external pattern generator. It clears and then enables the external signature register for a programmed number of patterns. It then makes a single-cycle comparison of the collected signature against an expected value.

A matching signature sets a pass flag. A mismatch raises an error interrupt. The interrupt stays set across later sessions until a dedicated clear input is asserted. The pattern generator and the signature register are separate blocks. This sequencer only produces their control strobes and reads the final signature.

The seed, pattern count and expected signature are captured when a start request is accepted. A start request that arrives while a session is running is dropped.

Top module: `bist_sequencer`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every output is low (test_mode_o, seed_load_o, tpg_en_o, misr_en_o, misr_clr_o, done_o, pass_o, irq_o, and seed_o is zero).
- R2: A start_i sampled high while idle captures seed_i, pat_count_i and golden_i. In the next cycle seed_load_o and misr_clr_o are both high for exactly one cycle, with seed_o equal to the captured seed.
- R3: After the load cycle, misr_en_o and tpg_en_o are high together for exactly N consecutive cycles, where N is the captured pattern count. A count of zero gives no enabled cycle.
- R4: test_mode_o is high from the load cycle through the done cycle of a session, and low while idle.
- R5: The cycle after the run phase is a single compare cycle. If sig_i equals the captured expected value in that cycle, pass_o is high from the next cycle until the next accepted start.
- R6: A signature mismatch in the compare cycle sets irq_o from the next cycle. irq_o then stays high, across later passing sessions, until irq_clr_i is sampled high.
- R7: If irq_clr_i is high in the same cycle as a compare that mismatches, irq_o is set (not cleared) on the next cycle.
- R8: done_o is high for exactly one cycle, N+3 cycles after the clock edge that accepted start. The block is idle (test_mode_o low) on the following cycle.
- R9: start_i sampled while a session is running has no effect: the captured seed, count and expected value are kept, and the session length is unchanged.
- R10: pass_o is cleared in the cycle after a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Session start request, honoured only while idle |
| seed_i | input | SEED_W | Seed for the pattern generator |
| pat_count_i | input | CNT_W | Number of patterns to apply |
| golden_i | input | SIG_W | Expected final signature |
| sig_i | input | SIG_W | Signature presented by the external signature register |
| irq_clr_i | input | 1 | Clears the error interrupt |
| test_mode_o | output | 1 | Circuit under test in test mode |
| seed_load_o | output | 1 | Load strobe for the pattern generator seed |
| seed_o | output | SEED_W | Captured seed value |
| tpg_en_o | output | 1 | Pattern generator advance enable |
| misr_en_o | output | 1 | Signature register capture enable |
| misr_clr_o | output | 1 | Signature register clear strobe |
| done_o | output | 1 | One-cycle session-complete pulse |
| pass_o | output | 1 | Last session matched its expected signature |
| irq_o | output | 1 | Sticky signature-mismatch interrupt |

## Verification
The embedded properties check the following on every cycle:
- the load and clear strobes are single-cycle;
- the enables never appear outside test mode;
- the pattern counter never underflows;
- a running session ignores start;
- the interrupt never drops without a clear, and a mismatching compare always sets it, even with a clear present;
- done is followed by idle.

Only the bench scenarios can show the rest: the exact number of enabled cycles for each programmed count, the position of the done pulse, the pass verdict against the expected signature, and that a start request during a run leaves the captured seed and session length untouched.

// File: rtl/bist_seq_pkg.sv
// Shared definitions for the self-test session sequencer.
package bist_seq_pkg;
    // Session phases; the order is only for readability.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_RUN  = 3'd2,
        ST_CMP  = 3'd3,
        ST_DONE = 3'd4
    } seq_state_e;
endpackage

// File: rtl/bist_pat_counter.sv
// Pattern budget counter.
// Loads the programmed count when a session is accepted and counts down once
// per run cycle. Assumes dec_i is only raised while the count is non-zero.
module bist_pat_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] value_i,
    input  logic             dec_i,
    output logic             empty_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Hold the remaining pattern count.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (load_i)  cnt_q <= value_i;
        else if (dec_i)   cnt_q <= cnt_q - ONE;
    end

    assign empty_o = (cnt_q == '0);
    assign last_o  = (cnt_q == ONE);

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> cnt_q != '0);
endmodule

// File: rtl/bist_seq_fsm.sv
// Session phase sequencer.
// Walks idle -> load -> run -> compare -> done -> idle. The run phase is
// skipped when the captured count is zero. Start is only accepted in idle.
module bist_seq_fsm
    import bist_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       cnt_empty_i,
    input  logic       cnt_last_i,
    output logic       accept_o,
    output seq_state_e state_o
);
    seq_state_e state_q, state_d;

    assign accept_o = (state_q == ST_IDLE) && start_i;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_LOAD;
            ST_LOAD: state_d = cnt_empty_i ? ST_CMP : ST_RUN;
            ST_RUN:  if (cnt_last_i) state_d = ST_CMP;
            ST_CMP:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> state_q != ST_LOAD);
    // R8
    done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DONE |=> state_q == ST_IDLE);
endmodule

// File: rtl/bist_judge.sv
// Signature judge.
// Compares the final signature in the compare cycle, keeps the pass flag
// until the next accepted start, and holds a sticky error interrupt. A set
// request wins over a clear request in the same cycle.
module bist_judge #(
    parameter int SIG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_i,
    input  logic             restart_i,
    input  logic [SIG_W-1:0] golden_i,
    input  logic [SIG_W-1:0] sig_i,
    input  logic             irq_clr_i,
    output logic             pass_o,
    output logic             irq_o
);
    logic match;
    logic pass_q, irq_q;

    assign match = (sig_i == golden_i);

    // Pass verdict of the latest session.
    always_ff @(posedge clk) begin
        if (!rst_n)         pass_q <= 1'b0;
        else if (restart_i) pass_q <= 1'b0;
        else if (cmp_i)     pass_q <= match;
    end

    // Sticky interrupt; a fresh error beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              irq_q <= 1'b0;
        else if (cmp_i && !match) irq_q <= 1'b1;
        else if (irq_clr_i)      irq_q <= 1'b0;
    end

    assign pass_o = pass_q;
    assign irq_o  = irq_q;

    // R6
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr_i) |=> irq_q);
    // R7
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_i && sig_i != golden_i) |=> irq_q);
    // R10
    pass_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !pass_q);
endmodule

// File: rtl/bist_sequencer.sv
// Self-test session sequencer (top).
// Captures seed, count and expected signature on an accepted start, drives
// test mode and the generator/signature-register strobes for one session,
// and reports pass and a sticky mismatch interrupt. Assumes the signature
// register output is valid in the compare cycle.
module bist_sequencer
    import bist_seq_pkg::*;
#(
    parameter int SEED_W = 8,
    parameter int CNT_W  = 4,
    parameter int SIG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic [CNT_W-1:0]  pat_count_i,
    input  logic [SIG_W-1:0]  golden_i,
    input  logic [SIG_W-1:0]  sig_i,
    input  logic              irq_clr_i,
    output logic              test_mode_o,
    output logic              seed_load_o,
    output logic [SEED_W-1:0] seed_o,
    output logic              tpg_en_o,
    output logic              misr_en_o,
    output logic              misr_clr_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              irq_o
);
    seq_state_e        state;
    logic              accept;
    logic              cnt_empty, cnt_last;
    logic [SEED_W-1:0] seed_q;
    logic [SIG_W-1:0]  golden_q;

    // Capture session settings when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q   <= '0;
            golden_q <= '0;
        end else if (accept) begin
            seed_q   <= seed_i;
            golden_q <= golden_i;
        end
    end

    bist_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cnt_empty_i (cnt_empty),
        .cnt_last_i  (cnt_last),
        .accept_o    (accept),
        .state_o     (state)
    );

    bist_pat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .value_i (pat_count_i),
        .dec_i   (state == ST_RUN),
        .empty_o (cnt_empty),
        .last_o  (cnt_last)
    );

    bist_judge #(.SIG_W(SIG_W)) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_i     (state == ST_CMP),
        .restart_i (accept),
        .golden_i  (golden_q),
        .sig_i     (sig_i),
        .irq_clr_i (irq_clr_i),
        .pass_o    (pass_o),
        .irq_o     (irq_o)
    );

    // Phase-decoded strobes.
    always_comb begin
        test_mode_o = (state != ST_IDLE);
        seed_load_o = (state == ST_LOAD);
        misr_clr_o  = (state == ST_LOAD);
        misr_en_o   = (state == ST_RUN);
        tpg_en_o    = (state == ST_RUN);
        done_o      = (state == ST_DONE);
    end
    assign seed_o = seed_q;

    // R2
    misr_clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misr_clr_o |=> !misr_clr_o);
    // R4
    enable_in_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (misr_en_o || seed_load_o) |-> test_mode_o);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !test_mode_o));
endmodule

// File: tb/sim_bist_sequencer.sv
module sim_bist_sequencer;
    localparam int SEED_W = 8, CNT_W = 4, SIG_W = 8;

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, irq_clr_i = 1'b0;
    logic [SEED_W-1:0] seed_i = '0;
    logic [CNT_W-1:0]  pat_count_i = '0;
    logic [SIG_W-1:0]  golden_i = '0, sig_i = '0;
    logic test_mode_o, seed_load_o, tpg_en_o, misr_en_o, misr_clr_o, done_o, pass_o, irq_o;
    logic [SEED_W-1:0] seed_o;

    int errors = 0, checks = 0;
    logic exp_irq = 1'b0;

    always #4 clk = ~clk;

    bist_sequencer #(.SEED_W(SEED_W), .CNT_W(CNT_W), .SIG_W(SIG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_i(seed_i),
        .pat_count_i(pat_count_i), .golden_i(golden_i), .sig_i(sig_i),
        .irq_clr_i(irq_clr_i), .test_mode_o(test_mode_o), .seed_load_o(seed_load_o),
        .seed_o(seed_o), .tpg_en_o(tpg_en_o), .misr_en_o(misr_en_o),
        .misr_clr_o(misr_clr_o), .done_o(done_o), .pass_o(pass_o), .irq_o(irq_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One session: n patterns, signature match or not, optional clear held,
    // optional busy start pulse in the second cycle.
    task automatic session(input int n, input logic match, input logic hold_clr,
                           input logic busy_start);
        logic [SEED_W-1:0] sd;
        logic [SIG_W-1:0]  gd;
        int en_cnt, ld_cnt, clr_cnt, done_cyc, cyc, tm_bad;
        sd = SEED_W'(8'h3C + n * 7);
        gd = SIG_W'(8'hA1 ^ n);
        @(negedge clk);
        start_i = 1'b1; seed_i = sd; pat_count_i = CNT_W'(n); golden_i = gd;
        sig_i = match ? gd : gd ^ 8'h5A;
        irq_clr_i = hold_clr;
        @(negedge clk);   // cycle 1: load
        start_i = 1'b0;
        en_cnt = 0; ld_cnt = 0; clr_cnt = 0; done_cyc = -1; tm_bad = 0;
        chk(pass_o == 1'b0, "R10 pass cleared", pass_o, 0);
        for (cyc = 1; cyc < 40; cyc++) begin
            if (cyc > 1) @(negedge clk);
            if (cyc == 2 && busy_start) begin
                start_i = 1'b1; seed_i = ~sd; pat_count_i = CNT_W'(n + 3); golden_i = ~gd;
            end else if (cyc == 3) begin
                start_i = 1'b0;
            end
            if (seed_load_o) begin
                ld_cnt++;
                chk(cyc == 1 && seed_o == sd, "R2 seed load cycle/value", cyc, 1);
            end
            if (misr_clr_o) clr_cnt++;
            if (misr_en_o) begin
                en_cnt++;
                chk(tpg_en_o && cyc >= 2 && cyc <= n + 1, "R3 enable window", cyc, 2);
            end
            if (!test_mode_o) tm_bad++;
            if (done_o) begin
                done_cyc = cyc;
                chk(pass_o == match, "R5 pass verdict", pass_o, match);
                exp_irq = exp_irq | !match;
                chk(irq_o == exp_irq, match ? "R6 irq" : "R7 irq set", irq_o, exp_irq);
                irq_clr_i = 1'b0;
                break;
            end
        end
        chk(ld_cnt == 1 && clr_cnt == 1, "R2 single strobes", ld_cnt + clr_cnt, 2);
        chk(en_cnt == n, "R3 pattern count", en_cnt, n);
        chk(tm_bad == 0, "R4 test mode held", tm_bad, 0);
        chk(done_cyc == n + 3, "R8 done position", done_cyc, n + 3);
        @(negedge clk);
        chk(!test_mode_o && !done_o, "R8 back to idle", test_mode_o, 0);
        if (busy_start) chk(seed_o == sd, "R9 seed kept", seed_o, sd);
        if (hold_clr && !match) exp_irq = 1'b1;
        else if (hold_clr) exp_irq = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr_i = 1'b1;
        @(negedge clk); irq_clr_i = 1'b0;
        exp_irq = 1'b0;
        chk(irq_o == 1'b0, "R6 clear", irq_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({test_mode_o, seed_load_o, tpg_en_o, misr_en_o, misr_clr_o, done_o, pass_o, irq_o} == 8'h00
            && seed_o == '0, "R1 reset outputs", int'(test_mode_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!test_mode_o && !irq_o && !pass_o, "R1 after release", irq_o, 0);
        for (int n = 0; n < 16; n++) begin
            session(n, 1'b1, 1'b0, 1'b0);
            session(n, 1'b0, 1'b0, 1'b0);
            session(n, 1'b1, 1'b0, 1'b0);
            chk(irq_o == 1'b1, "R6 sticky over pass", irq_o, 1);
            clear_irq();
        end
        session(5, 1'b0, 1'b1, 1'b0);
        chk(irq_o == 1'b1, "R7 set beats clear", irq_o, 1);
        clear_irq();
        session(4, 1'b1, 1'b0, 1'b1);
        session(0, 1'b0, 1'b0, 1'b1);
        clear_irq();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule